// File: doc/BRIEF.md
# Verdict-Driven Packet Dispatcher

This block sits behind a packet classifier and a packet store. The classifier issues a verdict for each stored packet, and the packets are stored in the same order as the verdicts. Each verdict is either a discard or a set of destinations. The set can hold the host path, any of the network ports, or both.

Verdicts pass through a chain of single-entry message slots. The slot at the classifier side comes first and the dispatcher's local slot comes last. The controller works on one packet at a time and has three states:

- ST_IDLE: waiting for a verdict.
- ST_COPY: replicating a kept packet word by word to every chosen destination.
- ST_FLUSH: reading a discarded packet out of the store and throwing it away.

The controller moves between states on four transitions:

- ST_IDLE to ST_COPY: a verdict is taken that keeps the packet and names at least one destination.
- ST_IDLE to ST_FLUSH: a verdict is taken that discards the packet, or that names no destination.
- ST_COPY to ST_IDLE: the end-of-packet word is delivered.
- ST_FLUSH to ST_IDLE: the end-of-packet word is discarded.

The packet store is read as a show-ahead FIFO. The head word and its end marker are visible whenever the store is not empty, and a read strobe pops the head word at the next clock edge.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, vrd_ready is 1 and out_valid, pf_rd and pf_flush are all 0.
- R2: A verdict is accepted in a cycle where vrd_valid and vrd_ready are both 1. Each slot holds one message and takes a new one only while it is empty. A message moves forward only into an empty slot. When every slot is occupied and the controller is busy, vrd_ready is 0.
- R3: The message in the local slot stays there until the controller is in ST_IDLE. With outputs stalled, exactly three verdicts are accepted: one in the controller and one in each slot.
- R4: A verdict consists of vrd_drop and a 5-bit mask vrd_dest. Bit 0 of the mask selects the host path and bits 1 to 4 select network ports 0 to 3.
- R5: A verdict with vrd_drop=1 makes the block pop the stored packet's words up to and including the word with pf_eop=1. pf_flush is 1 on each of these pops, out_valid stays 0, and out_ready has no effect on the flush.
- R6: A verdict with vrd_drop=0 and an all-zero mask is handled exactly like a discard.
- R7: For a kept packet, every selected destination gets every word, in store order. All selected destinations take each word in the same cycle. That cycle only occurs when all of them have out_ready=1.
- R8: out_valid is only raised for destinations in the current mask, and never while pf_empty is 1.
- R9: After the end word of a packet the controller returns to ST_IDLE. Packets are handled in verdict order, so a complete run leaves the store empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vrd_valid | input | 1 | Verdict present |
| vrd_ready | output | 1 | Classifier-side slot can take a verdict |
| vrd_drop | input | 1 | Discard the packet |
| vrd_dest | input | NUM_PORTS+1 | Destination mask: bit 0 host, bits 1.. network ports |
| pf_empty | input | 1 | Packet store has no word |
| pf_data | input | DATA_W | Head word of the packet store |
| pf_eop | input | 1 | Head word ends a packet |
| pf_rd | output | 1 | Pop the head word at the next edge |
| pf_flush | output | 1 | The current pop discards the word |
| out_ready | input | NUM_PORTS+1 | Per-destination ready |
| out_valid | output | NUM_PORTS+1 | Per-destination word strobe; the word is taken in this cycle |
| out_data | output | DATA_W | Word being delivered |
| out_eop | output | 1 | Delivered word ends the packet |

## Verification
The hardest state to reach from the ports is the one where both message slots are full behind a busy controller, because the controller normally drains the slots within a few cycles. The bench gets there by holding every out_ready low and offering four verdicts in a row. It then checks that only three are accepted and that nothing is popped. A separate sweep covers all 32 masks, both with and without the discard bit, against a ready pattern that differs per destination. It compares a per-destination order-sensitive hash with one computed from the packet contents.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COPY  = 2'd1,
        ST_FLUSH = 2'd2
    } disp_state_e;

    localparam int HOST_IDX = 0;
endpackage

// File: rtl/verdict_slot.sv
module verdict_slot #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_msg,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_msg
);
    logic         full;
    logic [W-1:0] hold;

    assign in_ready  = !full;
    assign out_valid = full;
    assign out_msg   = hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            hold <= '0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            hold <= in_msg;
        end else if (full && out_ready) begin
            full <= 1'b0;
        end
    end

    // R2
    held_msg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !out_ready) |=> (full && $stable(hold)));
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
    import pkt_dispatch_pkg::*;
#(
    parameter int NDEST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic             msg_drop,
    input  logic [NDEST-1:0] msg_dest,
    output logic             msg_take,
    input  logic             pf_empty,
    input  logic             pf_eop,
    output logic             pf_rd,
    output logic             pf_flush,
    input  logic [NDEST-1:0] out_ready,
    output logic [NDEST-1:0] out_valid
);
    disp_state_e      state, nxt;
    logic [NDEST-1:0] dest_q;
    logic             all_rdy;
    logic             discard;

    assign all_rdy = &(out_ready | ~dest_q);
    assign discard = msg_drop || (msg_dest == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            dest_q <= '0;
        end else begin
            state <= nxt;
            if (msg_take) dest_q <= discard ? '0 : msg_dest;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (msg_valid) nxt = discard ? ST_FLUSH : ST_COPY;
            ST_COPY:  if (!pf_empty && all_rdy && pf_eop) nxt = ST_IDLE;
            ST_FLUSH: if (!pf_empty && pf_eop) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        msg_take  = 1'b0;
        pf_rd     = 1'b0;
        pf_flush  = 1'b0;
        out_valid = '0;
        unique case (state)
            ST_IDLE:  msg_take = msg_valid;
            ST_COPY: begin
                if (!pf_empty && all_rdy) begin
                    pf_rd     = 1'b1;
                    out_valid = dest_q;
                end
            end
            ST_FLUSH: begin
                pf_rd    = !pf_empty;
                pf_flush = !pf_empty;
            end
            default: ;
        endcase
    end

    // R8
    no_send_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> !pf_empty);

    // R7
    lockstep_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> ((out_valid & ~out_ready) == '0));

    // R5
    flush_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_flush |-> (out_valid == '0 && pf_rd));

    // R9
    eop_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_rd && pf_eop) |=> (state == ST_IDLE));
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch #(
    parameter int DATA_W       = 16,
    parameter int NUM_PORTS    = 4,
    parameter int QUEUE_STAGES = 2,
    localparam int NDEST       = NUM_PORTS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vrd_valid,
    output logic              vrd_ready,
    input  logic              vrd_drop,
    input  logic [NDEST-1:0]  vrd_dest,
    input  logic              pf_empty,
    input  logic [DATA_W-1:0] pf_data,
    input  logic              pf_eop,
    output logic              pf_rd,
    output logic              pf_flush,
    input  logic [NDEST-1:0]  out_ready,
    output logic [NDEST-1:0]  out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eop
);
    localparam int MW = NDEST + 1;

    logic [QUEUE_STAGES:0] sv;
    logic [QUEUE_STAGES:0] sr;
    logic [MW-1:0]         sm [QUEUE_STAGES+1];

    assign sv[0]     = vrd_valid;
    assign sm[0]     = {vrd_drop, vrd_dest};
    assign vrd_ready = sr[0];

    for (genvar g = 0; g < QUEUE_STAGES; g++) begin : g_stage
        verdict_slot #(.W(MW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (sv[g]),
            .in_ready  (sr[g]),
            .in_msg    (sm[g]),
            .out_valid (sv[g+1]),
            .out_ready (sr[g+1]),
            .out_msg   (sm[g+1])
        );
    end

    dispatch_ctrl #(.NDEST(NDEST)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (sv[QUEUE_STAGES]),
        .msg_drop  (sm[QUEUE_STAGES][MW-1]),
        .msg_dest  (sm[QUEUE_STAGES][NDEST-1:0]),
        .msg_take  (sr[QUEUE_STAGES]),
        .pf_empty  (pf_empty),
        .pf_eop    (pf_eop),
        .pf_rd     (pf_rd),
        .pf_flush  (pf_flush),
        .out_ready (out_ready),
        .out_valid (out_valid)
    );

    assign out_data = pf_data;
    assign out_eop  = pf_eop;

    // R3
    local_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sv[QUEUE_STAGES] && !sr[QUEUE_STAGES]) |=> sv[QUEUE_STAGES]);
endmodule

// File: tb/pkt_dispatch_test.sv
`timescale 1ns/1ps
module pkt_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vrd_valid = 1'b0;
    logic        vrd_ready;
    logic        vrd_drop = 1'b0;
    logic [4:0]  vrd_dest = '0;
    logic        pf_empty;
    logic [15:0] pf_data;
    logic        pf_eop;
    logic        pf_rd, pf_flush;
    logic [4:0]  out_ready = '0;
    logic [4:0]  out_valid;
    logic [15:0] out_data;
    logic        out_eop;

    always #2 clk = ~clk;

    logic [15:0] mem [0:511];
    bit          meop [0:511];
    int          pkt_of [0:511];
    bit          vdrop [0:127];
    logic [4:0]  vdest [0:127];
    logic [4:0]  effm [0:127];

    int head, tail, vidx, vcnt, cyc, rmode;
    bit pop_pend, vacc;
    int cnt [5];
    int unsigned hsh [5];
    int ecnt [5];
    int unsigned eh [5];
    int flushw, fl6, exp_fl, exp_fl6, lockerr, emptyerr;
    int nchk = 0, nfail = 0;

    assign pf_empty = (head == tail);
    assign pf_data  = mem[head];
    assign pf_eop   = meop[head];

    pkt_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .vrd_valid(vrd_valid), .vrd_ready(vrd_ready),
        .vrd_drop(vrd_drop), .vrd_dest(vrd_dest),
        .pf_empty(pf_empty), .pf_data(pf_data), .pf_eop(pf_eop),
        .pf_rd(pf_rd), .pf_flush(pf_flush),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_eop(out_eop)
    );

    task automatic chk(string req, bit ok, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_state();
        head = 0; tail = 0; vidx = 0; vcnt = 0;
        pop_pend = 0; vacc = 0;
        flushw = 0; fl6 = 0; exp_fl = 0; exp_fl6 = 0; lockerr = 0; emptyerr = 0;
        for (int d = 0; d < 5; d++) begin
            cnt[d] = 0; hsh[d] = 0; ecnt[d] = 0; eh[d] = 0;
        end
    endtask

    task automatic add_pkt(bit drop, logic [4:0] m, int len);
        int pid;
        pid = vcnt;
        vdrop[pid] = drop;
        vdest[pid] = m;
        effm[pid]  = drop ? 5'd0 : m;
        for (int w = 0; w < len; w++) begin
            mem[tail]    = 16'(pid * 16 + w);
            meop[tail]   = (w == len - 1);
            pkt_of[tail] = pid;
            for (int d = 0; d < 5; d++)
                if (effm[pid][d]) begin
                    ecnt[d]++;
                    eh[d] = eh[d] * 31 + 32'(pid * 16 + w);
                end
            tail++;
        end
        if (effm[pid] == 0) exp_fl += len;
        if (!drop && m == 0) exp_fl6 += len;
        vcnt++;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (pop_pend) head++;
        if (vacc) vidx++;
        for (int d = 0; d < 5; d++)
            out_ready[d] = (rmode == 0) ? (((cyc + d * 7) % (d + 2)) != 0) : (rmode == 2);
        vrd_valid = (vidx < vcnt);
        vrd_drop  = vdrop[vidx];
        vrd_dest  = vdest[vidx];
        #1;
        if (rst_n) begin
            for (int d = 0; d < 5; d++)
                if (out_valid[d]) begin
                    cnt[d]++;
                    hsh[d] = hsh[d] * 31 + 32'(out_data);
                    if (!out_ready[d]) lockerr++;
                end
            if (|out_valid) begin
                if (head == tail) emptyerr++;
                else if (out_valid != effm[pkt_of[head]]) lockerr++;
            end
            if (pf_rd && pf_flush) begin
                flushw++;
                if (head < tail && !vdrop[pkt_of[head]]) fl6++;
            end
        end
        pop_pend = rst_n && pf_rd;
        vacc     = rst_n && vrd_valid && vrd_ready;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_state();
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic run_done(int lim);
        for (int i = 0; i < lim; i++) begin
            if (head == tail && vidx == vcnt) break;
            tick();
        end
        repeat (5) tick();
    endtask

    initial begin
        #800us;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        cyc = 0;
        rmode = 0;
        do_reset();
        tick();
        // R1 reset state
        chk("R1 vrd_ready", vrd_ready == 1'b1, int'(vrd_ready), 1);
        chk("R1 out_valid", out_valid == '0, int'(out_valid), 0);
        chk("R1 pf_rd", pf_rd == 1'b0, int'(pf_rd), 0);
        chk("R1 pf_flush", pf_flush == 1'b0, int'(pf_flush), 0);

        // Sweep: every mask, with and without discard (R4 R6 R7)
        for (int i = 0; i < 64; i++) add_pkt(i[5], i[4:0], 1 + (i % 4));
        run_done(20000);
        for (int d = 0; d < 5; d++) begin
            chk($sformatf("R4 R7 count dest%0d", d), cnt[d] == ecnt[d], cnt[d], ecnt[d]);
            chk($sformatf("R7 order hash dest%0d", d), hsh[d] == eh[d], int'(hsh[d]), int'(eh[d]));
        end
        chk("R5 flushed words", flushw == exp_fl, flushw, exp_fl);
        chk("R6 empty mask flushed", fl6 == exp_fl6, fl6, exp_fl6);
        chk("R7 lockstep errors", lockerr == 0, lockerr, 0);
        chk("R8 send while empty", emptyerr == 0, emptyerr, 0);
        chk("R9 verdicts consumed", vidx == vcnt, vidx, vcnt);
        chk("R9 store drained", head == tail, head, tail);

        // Both slots full behind a stalled controller (R2 R3)
        rmode = 1;
        do_reset();
        for (int i = 0; i < 4; i++) add_pkt(1'b0, 5'h1f, 2);
        repeat (20) tick();
        chk("R2 R3 accepted under stall", vidx == 3, vidx, 3);
        chk("R2 ready low when full", vrd_ready == 1'b0, int'(vrd_ready), 0);
        chk("R7 no pop while not ready", head == 0, head, 0);
        chk("R7 no delivery while not ready", cnt[0] == 0, cnt[0], 0);
        rmode = 2;
        run_done(2000);
        chk("R9 stall run drained", head == tail, head, tail);
        for (int d = 0; d < 5; d++)
            chk($sformatf("R7 stall run dest%0d", d), cnt[d] == 8 && hsh[d] == eh[d], cnt[d], 8);

        // Discard proceeds with every ready low (R5)
        rmode = 1;
        do_reset();
        add_pkt(1'b1, 5'h1f, 3);
        repeat (15) tick();
        chk("R5 drop ignores ready", head == tail, head, tail);
        chk("R5 drop flush count", flushw == 3, flushw, 3);
        chk("R5 drop silent", cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4] == 0,
            cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4], 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule